// File: doc/BRIEF.md
# Zigzag Scan Coordinate Sequencer

This block walks an N x N pixel array (N = 8 by default) in the zigzag order used by block transform coders. It presents one one-based (x, y) coordinate at a time together with the matching row-major linear address. A consumer takes each coordinate by raising an advance input while the coordinate is valid. The sequencer then moves to the next position in the following cycle.

The order is not held in a table. A small built-in program of movement primitives produces it. The primitives are a single step east, a single step south, and two diagonal runs, south-west and north-east. A diagonal run repeats its step until the counter lands on an array edge, or until it has made N steps. The program runs the first half of the pattern. It then runs one long south-west diagonal. It finishes with the mirror image of the first half, played in reverse, which carries the counter to the far corner. A start pulse restarts the walk from the origin at any time. After the final corner is presented, a done flag holds until the next start.

Top module: `zigzag_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, vld_o and done_o are 0.
- R2: One cycle after a start pulse, vld_o is 1, the coordinate is x_o=1, y_o=1, addr_o is 0 and done_o is 0.
- R3: In a cycle where vld_o is 1 and adv_i is 0, the coordinate does not change in the next cycle.
- R4: Each accepted advance moves to the next position in this order. The anti-diagonals s = x + y are visited from 2 up to 2N. On an odd s, x decreases along the diagonal. On an even s, x increases.
- R5: A full walk takes exactly N*N-1 accepted advances. It presents all N*N positions once each, and done_o stays 0 until the last one.
- R6: done_o rises together with the coordinate (N, N). It stays 1, and the coordinate holds, while adv_i keeps being asserted, until start_i is pulsed again.
- R7: addr_o equals (y_o-1)*N + (x_o-1) for every presented coordinate.
- R8: A start pulse in the middle of a walk abandons it. The next cycle presents (1, 1) with done_o at 0.
- R9: Before the first start pulse after reset, adv_i has no effect: vld_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart the walk at (1, 1) |
| adv_i | input | 1 | Consumer accepts the presented coordinate |
| vld_o | output | 1 | A coordinate is being presented |
| x_o | output | $clog2(N+1) | Column, one-based |
| y_o | output | $clog2(N+1) | Row, one-based |
| addr_o | output | $clog2(N*N) | Row-major linear address |
| done_o | output | 1 | Last position (N, N) is presented |

## Verification
The case hardest to reach from the ports is a diagonal run that is held mid-way by a stalled consumer. The run's internal step count must survive the pause, so that the run still ends on the correct edge. To reach this, the bench walks the whole pattern a second time with advance gated by an irregular pattern, so stalls land inside many diagonal runs on both halves of the array. Every presented coordinate is compared against an order computed from the anti-diagonal rule. A restart is also issued partway through a diagonal run, to show that the run's state does not leak into the new walk.

// File: rtl/zigzag_seq.sv
module zigzag_seq #(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1),
  localparam int AW = $clog2(N * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          adv_i,
  output logic          vld_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);

  localparam int P    = (N - 2) / 2;
  localparam int HALF = 1 + 4 * P;
  localparam int L    = 2 * HALF + 1;
  localparam int IW   = $clog2(L + 1);

  typedef enum logic [1:0] {OP_E, OP_S, OP_SW, OP_NE} op_t;

  logic [IW-1:0] idx;
  logic [CW-1:0] iter;
  op_t           op;
  logic [1:0]    r1;
  logic [IW-1:0] r2;
  logic [CW-1:0] nx, ny;
  logic          edge_hit, fin, next_op;

  always_comb begin
    r1 = 2'(idx - IW'(1));
    r2 = idx - IW'(HALF + 1);
    if (idx == '0)
      op = OP_E;
    else if (idx < IW'(HALF))
      case (r1)
        2'd0:    op = OP_SW;
        2'd1:    op = OP_S;
        2'd2:    op = OP_NE;
        default: op = OP_E;
      endcase
    else if (idx == IW'(HALF))
      op = OP_SW;
    else if (r2 < IW'(4 * P))
      case (r2[1:0])
        2'd0:    op = OP_E;
        2'd1:    op = OP_NE;
        2'd2:    op = OP_S;
        default: op = OP_SW;
      endcase
    else
      op = OP_E;
  end

  always_comb begin
    nx = x_o;
    ny = y_o;
    case (op)
      OP_E:    nx = x_o + 1'b1;
      OP_S:    ny = y_o + 1'b1;
      OP_SW:   begin nx = x_o - 1'b1; ny = y_o + 1'b1; end
      default: begin nx = x_o + 1'b1; ny = y_o - 1'b1; end
    endcase
  end

  assign edge_hit = (nx == CW'(1)) || (nx == CW'(N)) || (ny == CW'(1)) || (ny == CW'(N));
  assign next_op  = (op == OP_E) || (op == OP_S) || edge_hit || (iter == CW'(N - 1));
  assign fin      = (idx == IW'(L));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      x_o   <= CW'(1);
      y_o   <= CW'(1);
      idx   <= '0;
      iter  <= '0;
    end else if (start_i) begin
      vld_o <= 1'b1;
      x_o   <= CW'(1);
      y_o   <= CW'(1);
      idx   <= '0;
      iter  <= '0;
    end else if (vld_o && adv_i && !fin) begin
      x_o <= nx;
      y_o <= ny;
      if (next_op) begin
        idx  <= idx + 1'b1;
        iter <= '0;
      end else begin
        iter <= iter + 1'b1;
      end
    end
  end

  assign done_o = vld_o && fin;
  assign addr_o = AW'(y_o - 1'b1) * AW'(N) + AW'(x_o - 1'b1);

endmodule

// File: rtl/zigzag_seq_chk.sv
module zigzag_seq_chk #(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          adv_i,
  input logic          vld_o,
  input logic [CW-1:0] x_o,
  input logic [CW-1:0] y_o,
  input logic [AW-1:0] addr_o,
  input logic          done_o
);

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> vld_o && x_o == CW'(1) && y_o == CW'(1) && !done_o); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && !adv_i && !start_i |=> $stable(x_o) && $stable(y_o)); // R3

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && adv_i && !done_o && !start_i |=> (x_o != $past(x_o)) || (y_o != $past(y_o))); // R4

  AST_DONE_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> x_o == CW'(N) && y_o == CW'(N)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(addr_o)); // R6

  AST_ADDR_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o && x_o == CW'(1) && y_o == CW'(1) |-> addr_o == '0); // R7

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o && !start_i |=> !vld_o && !done_o); // R9

endmodule

bind zigzag_seq zigzag_seq_chk #(.N(N), .CW(CW), .AW(AW)) u_chk (.*);

// File: tb/sim_zigzag_seq.sv
`timescale 1ns/1ps
module sim_zigzag_seq;
  localparam int N  = 8;
  localparam int NN = N * N;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       adv_i = 1'b0;
  logic       vld_o, done_o;
  logic [3:0] x_o, y_o;
  logic [5:0] addr_o;

  int errors = 0;
  int checks = 0;
  int ex [NN];
  int ey [NN];

  zigzag_seq #(.N(N)) u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_order();
    int k = 0;
    for (int s = 2; s <= 2 * N; s++) begin
      int lo = (s - N > 1) ? s - N : 1;
      int hi = (s - 1 < N) ? s - 1 : N;
      if (s % 2 == 1)
        for (int x = hi; x >= lo; x--) begin ex[k] = x; ey[k] = s - x; k++; end
      else
        for (int x = lo; x <= hi; x++) begin ex[k] = x; ey[k] = s - x; k++; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1; adv_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!vld_o && !done_o, "R1 reset idle", {vld_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!vld_o && !done_o, "R1 after reset", {vld_o, done_o}, 0);
  endtask

  task automatic t_idle_adv();
    adv_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!vld_o, "R9 advance before start", vld_o, 0);
    adv_i = 1'b0;
  endtask

  task automatic t_full();
    int bad_pos = 0, bad_addr = 0, early_done = 0, k = 0;
    pulse_start();
    chk(vld_o && x_o == 1 && y_o == 1 && addr_o == 0 && !done_o, "R2 origin",
        {x_o, y_o}, 17);
    while (k < NN - 1) begin
      if (x_o != ex[k] || y_o != ey[k]) begin
        bad_pos++;
        $display("FAIL R4 step %0d actual=(%0d,%0d) expected=(%0d,%0d)", k, x_o, y_o, ex[k], ey[k]);
      end
      if (addr_o != (ey[k] - 1) * N + ex[k] - 1) bad_addr++;
      if (done_o) early_done++;
      adv_i = 1'b1;
      @(negedge clk);
      k++;
    end
    adv_i = 1'b0;
    checks++;
    if (bad_pos != 0) errors++;
    chk(bad_addr == 0, "R7 address map", bad_addr, 0);
    chk(early_done == 0, "R5 done early", early_done, 0);
    chk(x_o == N && y_o == N, "R5 last corner", {x_o, y_o}, 136);
    chk(done_o, "R6 done at corner", done_o, 1);
    chk(addr_o == NN - 1, "R7 last address", addr_o, NN - 1);
  endtask

  task automatic t_done_hold();
    adv_i = 1'b1;
    repeat (5) @(negedge clk);
    adv_i = 1'b0;
    chk(done_o && x_o == N && y_o == N, "R6 hold after done", {done_o, x_o, y_o}, 392);
  endtask

  task automatic t_stall();
    int k = 0, bad = 0, cyc = 0, stalls = 0;
    pulse_start();
    while (k < NN - 1 && cyc < 400) begin
      bit a = ((cyc % 3) != 0) && ((cyc % 7) != 5);
      if (x_o != ex[k] || y_o != ey[k]) begin
        bad++;
        $display("FAIL R3 cycle %0d actual=(%0d,%0d) expected=(%0d,%0d)", cyc, x_o, y_o, ex[k], ey[k]);
      end
      if (!a) stalls++;
      adv_i = a;
      @(negedge clk);
      if (a) k++;
      cyc++;
    end
    adv_i = 1'b0;
    checks++;
    if (bad != 0) errors++;
    chk(stalls > 20, "R3 stall coverage", stalls, 21);
    chk(k == NN - 1 && done_o && x_o == N && y_o == N, "R5 stalled walk end", k, NN - 1);
  endtask

  task automatic t_restart();
    pulse_start();
    adv_i = 1'b1;
    repeat (12) @(negedge clk);
    adv_i = 1'b0;
    chk(x_o == ex[12] && y_o == ey[12], "R4 mid walk", {x_o, y_o}, ex[12] * 16 + ey[12]);
    @(negedge clk); start_i = 1'b1; adv_i = 1'b1;
    @(negedge clk); start_i = 1'b0; adv_i = 1'b0;
    chk(x_o == 1 && y_o == 1 && !done_o && vld_o, "R8 restart origin", {x_o, y_o}, 17);
    adv_i = 1'b1;
    repeat (3) @(negedge clk);
    adv_i = 1'b0;
    chk(x_o == ex[3] && y_o == ey[3], "R8 fresh diagonal", {x_o, y_o}, ex[3] * 16 + ey[3]);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    build_order();
    t_reset();
    t_idle_adv();
    t_full();
    t_done_hold();
    t_stall();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule